// File: doc/BRIEF.md
# Interrupt Acceptance and Vectoring Controller

This block decides, cycle by cycle, whether an 8-bit processor core takes an interrupt, and where execution goes when it does. It keeps a primary and a backup interrupt-enable flag, a two-bit vectoring mode and an 8-bit vector-base register. The core drives single-cycle command strobes for enabling, disabling, choosing the mode, loading the vector base and returning from an interrupt handler. Interrupting devices drive a maskable request level, a non-maskable request line and a data byte.

When a request is taken, the block raises `accept` for one clock. In the same cycle it presents the new program counter, a flag asking the core to push its return address, the cycle cost of the entry sequence, and, in the mode that executes the device's byte, a request to execute that byte with the byte itself. All results come from registers, one clock after the request is sampled. Opcode execution, the stack and bus timing belong to the core.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A synchronous reset clears both enable flags, selects the execute-byte mode (mode 0) and loads 0xFF into the vector base, so a later table-mode entry with device byte 0x5A targets 0xFF5A. While reset is held, `accept` stays low.
- R2: While the primary flag is clear, a maskable request does not produce `accept`, however long it is held.
- R3: Taking a maskable request clears both enable flags. The cleared flags show on `en_pri` and `en_bak` in the same cycle as the `accept` pulse.
- R4: A rising edge on `nmi_req` is taken whatever the flags hold. It targets 0x0066 with a cost of 13 and with `push_ret` set. It clears the primary flag and leaves the backup flag unchanged.
- R5: In mode 1 a taken maskable request targets 0x0038 with a cost of 13 and with `push_ret` set.
- R6: In mode 2 a taken maskable request targets {vector base, device byte}, with the vector base as the high byte. It costs 19 and sets `push_ret`.
- R7: In mode 0 a taken maskable request raises `exec_req` with `exec_byte` equal to the device byte. `push_ret` is 0, the cost is 0 and the target is 0x0000.
- R8: `cmd_enable` sets both flags and `cmd_disable` clears both. When both strobes arrive in the same cycle, the disable wins.
- R9: `cmd_retn` and `cmd_reti` each copy the backup flag into the primary flag and leave the backup flag as it was.
- R10: `cmd_setmode` takes the mode from the 3-bit `mode_sel`. Selector values 0, 1, 4 and 5 give mode 0, values 2 and 6 give mode 1, and values 3 and 7 give mode 2.
- R11: When a non-maskable edge and a takeable maskable request arrive in the same cycle, only the non-maskable one is taken, with its own target. The maskable request is not taken in the following cycle either.
- R12: `accept` lasts exactly one clock per taken request. A non-maskable line held high produces one acceptance only.
- R13: `vec_load` writes `vec_data` into the vector base register.
- R14: In a cycle where a request is taken, the flag change caused by the acceptance overrides any enable, disable or return strobe in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_req | input | 1 | Non-maskable request, taken on its rising edge |
| int_req | input | 1 | Maskable request level |
| dev_byte | input | 8 | Byte supplied by the interrupting device |
| cmd_enable | input | 1 | Strobe: set both enable flags |
| cmd_disable | input | 1 | Strobe: clear both enable flags |
| cmd_setmode | input | 1 | Strobe: load the mode from mode_sel |
| mode_sel | input | 3 | Mode selector for cmd_setmode |
| cmd_retn | input | 1 | Strobe: return from non-maskable handler |
| cmd_reti | input | 1 | Strobe: return from maskable handler |
| vec_load | input | 1 | Strobe: load the vector base register |
| vec_data | input | 8 | New vector base value |
| accept | output | 1 | One-cycle pulse when a request is taken |
| target_pc | output | 16 | Program counter to continue from |
| push_ret | output | 1 | Core must push its return address |
| cycle_cost | output | 5 | Cycles charged for the entry sequence |
| exec_req | output | 1 | Core must execute exec_byte as an opcode |
| exec_byte | output | 8 | Device byte to execute |
| en_pri | output | 1 | Primary enable flag |
| en_bak | output | 1 | Backup enable flag |

## Verification
The hardest case to reach is a backup flag that differs from the primary flag. Only a non-maskable entry makes them differ, so the stimulus enables both flags, fires a non-maskable edge, and then issues a return strobe to show the saved value coming back. The same path is run with a disable strobe in the acceptance cycle, and with both request kinds together, so that priority and override are seen on the flag outputs. Mode decoding is covered by going through all eight selector values. Each value is followed by a real maskable entry, and the bench checks which target class comes out.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    IM_EXEC  = 2'd0,
    IM_FIXED = 2'd1,
    IM_TABLE = 2'd2
  } irq_mode_e;

  // Selector bits [1:0] alone choose the mode; bit 2 is a don't-care.
  function automatic irq_mode_e sel_to_mode(input logic [2:0] sel);
    irq_mode_e m;
    case (sel[1:0])
      2'd2:    m = IM_FIXED;
      2'd3:    m = IM_TABLE;
      default: m = IM_EXEC;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/irq_enable_flags.sv
module irq_enable_flags (
  input  logic clk,
  input  logic rst,
  input  logic take_mask,
  input  logic take_nmi,
  input  logic cmd_enable,
  input  logic cmd_disable,
  input  logic cmd_ret,
  output logic pri,
  output logic bak
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pri <= 1'b0;
      bak <= 1'b0;
    end else if (take_mask) begin
      pri <= 1'b0;
      bak <= 1'b0;
    end else if (take_nmi) begin
      pri <= 1'b0;
    end else if (cmd_disable) begin
      pri <= 1'b0;
      bak <= 1'b0;
    end else if (cmd_enable) begin
      pri <= 1'b1;
      bak <= 1'b1;
    end else if (cmd_ret) begin
      pri <= bak;
    end
  end

endmodule

// File: rtl/irq_mode_vec.sv
module irq_mode_vec
  import irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_setmode,
  input  logic [2:0]        mode_sel,
  input  logic              vec_load,
  input  logic [DATA_W-1:0] vec_data,
  output irq_mode_e         mode,
  output logic [DATA_W-1:0] vec
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= IM_EXEC;
      vec  <= '1;
    end else begin
      if (cmd_setmode) mode <= sel_to_mode(mode_sel);
      if (vec_load)    vec  <= vec_data;
    end
  end

endmodule

// File: rtl/irq_nmi_detect.sv
module irq_nmi_detect #(
  parameter bit NMI_EDGE = 1'b1
) (
  input  logic clk,
  input  logic nmi_req,
  output logic nmi_take
);

  generate
    if (NMI_EDGE) begin : g_edge
      logic nmi_prev;
      always_ff @(posedge clk) nmi_prev <= nmi_req;
      assign nmi_take = nmi_req & ~nmi_prev;
    end else begin : g_level
      assign nmi_take = nmi_req;
    end
  endgenerate

endmodule

// File: rtl/irq_target_gen.sv
module irq_target_gen
  import irq_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          COST_W     = 5,
  parameter logic [15:0] NMI_ADDR   = 16'h0066,
  parameter logic [15:0] FIXED_ADDR = 16'h0038,
  parameter int          NMI_COST   = 13,
  parameter int          FIXED_COST = 13,
  parameter int          TABLE_COST = 19
) (
  input  logic              take_nmi,
  input  irq_mode_e         mode,
  input  logic [DATA_W-1:0] vec,
  input  logic [DATA_W-1:0] dev_byte,
  output logic [ADDR_W-1:0] pc,
  output logic              push,
  output logic [COST_W-1:0] cost,
  output logic              exec
);

  always_comb begin
    pc   = '0;
    push = 1'b0;
    cost = '0;
    exec = 1'b0;
    if (take_nmi) begin
      pc   = ADDR_W'(NMI_ADDR);
      push = 1'b1;
      cost = COST_W'(NMI_COST);
    end else begin
      case (mode)
        IM_FIXED: begin
          pc   = ADDR_W'(FIXED_ADDR);
          push = 1'b1;
          cost = COST_W'(FIXED_COST);
        end
        IM_TABLE: begin
          pc   = ADDR_W'({vec, dev_byte});
          push = 1'b1;
          cost = COST_W'(TABLE_COST);
        end
        default: exec = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 2 * DATA_W,
  parameter int          COST_W     = 5,
  parameter logic [15:0] NMI_ADDR   = 16'h0066,
  parameter logic [15:0] FIXED_ADDR = 16'h0038,
  parameter int          NMI_COST   = 13,
  parameter int          FIXED_COST = 13,
  parameter int          TABLE_COST = 19,
  parameter bit          NMI_EDGE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_req,
  input  logic              int_req,
  input  logic [DATA_W-1:0] dev_byte,
  input  logic              cmd_enable,
  input  logic              cmd_disable,
  input  logic              cmd_setmode,
  input  logic [2:0]        mode_sel,
  input  logic              cmd_retn,
  input  logic              cmd_reti,
  input  logic              vec_load,
  input  logic [DATA_W-1:0] vec_data,
  output logic              accept,
  output logic [ADDR_W-1:0] target_pc,
  output logic              push_ret,
  output logic [COST_W-1:0] cycle_cost,
  output logic              exec_req,
  output logic [DATA_W-1:0] exec_byte,
  output logic              en_pri,
  output logic              en_bak
);

  irq_mode_e         mode;
  logic [DATA_W-1:0] vec;
  logic              nmi_take;
  logic              mask_take;
  logic              any_take;
  logic [ADDR_W-1:0] nxt_pc;
  logic              nxt_push;
  logic [COST_W-1:0] nxt_cost;
  logic              nxt_exec;

  irq_nmi_detect #(.NMI_EDGE(NMI_EDGE)) u_nmi (
    .clk      (clk),
    .nmi_req  (nmi_req),
    .nmi_take (nmi_take)
  );

  assign mask_take = int_req & en_pri & ~nmi_take;
  assign any_take  = mask_take | nmi_take;

  irq_enable_flags u_flags (
    .clk         (clk),
    .rst         (rst),
    .take_mask   (mask_take),
    .take_nmi    (nmi_take),
    .cmd_enable  (cmd_enable),
    .cmd_disable (cmd_disable),
    .cmd_ret     (cmd_retn | cmd_reti),
    .pri         (en_pri),
    .bak         (en_bak)
  );

  irq_mode_vec #(.DATA_W(DATA_W)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .cmd_setmode (cmd_setmode),
    .mode_sel    (mode_sel),
    .vec_load    (vec_load),
    .vec_data    (vec_data),
    .mode        (mode),
    .vec         (vec)
  );

  irq_target_gen #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .COST_W     (COST_W),
    .NMI_ADDR   (NMI_ADDR),
    .FIXED_ADDR (FIXED_ADDR),
    .NMI_COST   (NMI_COST),
    .FIXED_COST (FIXED_COST),
    .TABLE_COST (TABLE_COST)
  ) u_tgt (
    .take_nmi (nmi_take),
    .mode     (mode),
    .vec      (vec),
    .dev_byte (dev_byte),
    .pc       (nxt_pc),
    .push     (nxt_push),
    .cost     (nxt_cost),
    .exec     (nxt_exec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept     <= 1'b0;
      target_pc  <= '0;
      push_ret   <= 1'b0;
      cycle_cost <= '0;
      exec_req   <= 1'b0;
      exec_byte  <= '0;
    end else begin
      accept     <= any_take;
      target_pc  <= any_take ? nxt_pc : '0;
      push_ret   <= any_take & nxt_push;
      cycle_cost <= any_take ? nxt_cost : '0;
      exec_req   <= any_take & nxt_exec;
      exec_byte  <= (any_take & nxt_exec) ? dev_byte : '0;
    end
  end

endmodule

// File: rtl/irq_accept_ctrl_chk.sv
module irq_accept_ctrl_chk #(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter int          COST_W   = 5,
  parameter logic [15:0] NMI_ADDR = 16'h0066,
  parameter int          NMI_COST = 13,
  parameter bit          NMI_EDGE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              nmi_req,
  input logic              int_req,
  input logic              cmd_enable,
  input logic              cmd_disable,
  input logic              cmd_retn,
  input logic              cmd_reti,
  input logic              accept,
  input logic [ADDR_W-1:0] target_pc,
  input logic              push_ret,
  input logic [COST_W-1:0] cycle_cost,
  input logic              en_pri,
  input logic              en_bak
);

  assert_mask_block_R2: assert property (@(posedge clk) disable iff (rst)
    (int_req && !en_pri && !nmi_req) |=> !accept);

  assert_mask_clear_R3: assert property (@(posedge clk) disable iff (rst)
    (int_req && en_pri && !nmi_req) |=> (accept && !en_pri && !en_bak));

  assert_nmi_entry_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi_req) |=> (accept && push_ret && target_pc == ADDR_W'(NMI_ADDR)
                        && cycle_cost == COST_W'(NMI_COST) && !en_pri
                        && en_bak == $past(en_bak)));

  assert_disable_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_disable && !$rose(nmi_req)) |=> (!en_pri && !en_bak));

  assert_return_copy_R9: assert property (@(posedge clk) disable iff (rst)
    ((cmd_retn || cmd_reti) && !cmd_enable && !cmd_disable && !$rose(nmi_req)
     && !(int_req && en_pri)) |=> (en_pri == $past(en_bak) && en_bak == $past(en_bak)));

  generate
    if (NMI_EDGE) begin : g_pulse
      assert_nmi_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        (accept && target_pc == ADDR_W'(NMI_ADDR) && cycle_cost == COST_W'(NMI_COST))
        |=> !(accept && target_pc == ADDR_W'(NMI_ADDR) && cycle_cost == COST_W'(NMI_COST)));
    end
  endgenerate

endmodule

bind irq_accept_ctrl irq_accept_ctrl_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .COST_W   (COST_W),
  .NMI_ADDR (NMI_ADDR),
  .NMI_COST (NMI_COST),
  .NMI_EDGE (NMI_EDGE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .nmi_req     (nmi_req),
  .int_req     (int_req),
  .cmd_enable  (cmd_enable),
  .cmd_disable (cmd_disable),
  .cmd_retn    (cmd_retn),
  .cmd_reti    (cmd_reti),
  .accept      (accept),
  .target_pc   (target_pc),
  .push_ret    (push_ret),
  .cycle_cost  (cycle_cost),
  .en_pri      (en_pri),
  .en_bak      (en_bak)
);

// File: tb/tb_irq_accept_ctrl.sv
module tb_irq_accept_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        nmi_req = 1'b0, int_req = 1'b0;
  logic [7:0]  dev_byte = '0;
  logic        cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_setmode = 1'b0;
  logic [2:0]  mode_sel = '0;
  logic        cmd_retn = 1'b0, cmd_reti = 1'b0, vec_load = 1'b0;
  logic [7:0]  vec_data = '0;
  logic        accept, push_ret, exec_req, en_pri, en_bak;
  logic [15:0] target_pc;
  logic [4:0]  cycle_cost;
  logic [7:0]  exec_byte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_accept_ctrl dut (
    .clk(clk), .rst(rst), .nmi_req(nmi_req), .int_req(int_req), .dev_byte(dev_byte),
    .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_setmode(cmd_setmode),
    .mode_sel(mode_sel), .cmd_retn(cmd_retn), .cmd_reti(cmd_reti),
    .vec_load(vec_load), .vec_data(vec_data), .accept(accept), .target_pc(target_pc),
    .push_ret(push_ret), .cycle_cost(cycle_cost), .exec_req(exec_req),
    .exec_byte(exec_byte), .en_pri(en_pri), .en_bak(en_bak)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic clear_in();
    int_req = 0; cmd_enable = 0; cmd_disable = 0; cmd_setmode = 0;
    cmd_retn = 0; cmd_reti = 0; vec_load = 0; nmi_req = 0;
  endtask

  task automatic strobe_enable();
    cmd_enable = 1; tick(); cmd_enable = 0;
  endtask

  task automatic strobe_disable();
    cmd_disable = 1; tick(); cmd_disable = 0;
  endtask

  task automatic set_mode(input logic [2:0] s);
    cmd_setmode = 1; mode_sel = s; tick(); cmd_setmode = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick();
    chk("R1 accept in reset", accept, 0);
    rst = 0; tick();
    chk("R1 en_pri", en_pri, 0);
    chk("R1 en_bak", en_bak, 0);
    chk("R1 accept", accept, 0);
    chk("R1 exec_req", exec_req, 0);
  endtask

  // R10 decode, R5/R6/R7 targets, R1 vector 0xFF, R3 clearing, R12 pulse
  task automatic t_modesel();
    for (int s = 0; s < 8; s++) begin
      int em;
      em = (s == 2 || s == 6) ? 1 : ((s == 3 || s == 7) ? 2 : 0);
      set_mode(3'(s));
      strobe_enable();
      int_req = 1; dev_byte = 8'h5A; tick();
      chk($sformatf("R10 accept sel=%0d", s), accept, 1);
      if (em == 0) begin
        chk("R7 exec_req", exec_req, 1);
        chk("R7 exec_byte", exec_byte, 8'h5A);
        chk("R7 push_ret", push_ret, 0);
        chk("R7 cost", cycle_cost, 0);
        chk("R7 pc", target_pc, 16'h0000);
      end else if (em == 1) begin
        chk("R5 pc", target_pc, 16'h0038);
        chk("R5 cost", cycle_cost, 13);
        chk("R5 push_ret", push_ret, 1);
        chk("R5 exec_req", exec_req, 0);
      end else begin
        chk("R1 R6 pc with reset vector", target_pc, 16'hFF5A);
        chk("R6 cost", cycle_cost, 19);
        chk("R6 push_ret", push_ret, 1);
      end
      chk("R3 en_pri", en_pri, 0);
      chk("R3 en_bak", en_bak, 0);
      tick();
      chk("R12 accept drops", accept, 0);
      int_req = 0; tick();
    end
  endtask

  task automatic t_masked();
    strobe_disable();
    int_req = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 masked request ignored", accept, 0);
    end
    int_req = 0; tick();
  endtask

  task automatic t_flags();
    strobe_enable();
    chk("R8 enable pri", en_pri, 1);
    chk("R8 enable bak", en_bak, 1);
    strobe_disable();
    chk("R8 disable pri", en_pri, 0);
    chk("R8 disable bak", en_bak, 0);
    strobe_enable();
    cmd_enable = 1; cmd_disable = 1; tick(); clear_in();
    chk("R8 disable wins pri", en_pri, 0);
    chk("R8 disable wins bak", en_bak, 0);
  endtask

  task automatic t_vecload();
    vec_load = 1; vec_data = 8'h80; tick(); vec_load = 0;
    set_mode(3'd3);
    strobe_enable();
    int_req = 1; dev_byte = 8'h40; tick();
    chk("R13 R6 pc", target_pc, 16'h8040);
    chk("R6 cost", cycle_cost, 19);
    int_req = 0; tick();
  endtask

  task automatic t_nmi();
    strobe_enable();
    nmi_req = 1; tick();
    chk("R4 accept", accept, 1);
    chk("R4 pc", target_pc, 16'h0066);
    chk("R4 cost", cycle_cost, 13);
    chk("R4 push", push_ret, 1);
    chk("R4 exec_req", exec_req, 0);
    chk("R4 pri cleared", en_pri, 0);
    chk("R4 bak kept", en_bak, 1);
    nmi_req = 0; tick();
    cmd_reti = 1; tick(); cmd_reti = 0;
    chk("R9 reti restores pri", en_pri, 1);
    chk("R9 reti bak", en_bak, 1);
    strobe_disable();
    nmi_req = 1; tick();
    chk("R4 accepted with flags off", accept, 1);
    chk("R4 bak stays 0", en_bak, 0);
    nmi_req = 0; tick();
    cmd_retn = 1; tick(); cmd_retn = 0;
    chk("R9 retn copies 0", en_pri, 0);
  endtask

  task automatic t_both();
    strobe_enable();
    int_req = 1; nmi_req = 1; dev_byte = 8'h22; tick();
    chk("R11 accept", accept, 1);
    chk("R11 nmi target", target_pc, 16'h0066);
    chk("R11 bak kept", en_bak, 1);
    tick();
    chk("R11 maskable not taken after", accept, 0);
    clear_in(); tick();
  endtask

  task automatic t_held();
    int n = 0;
    strobe_disable();
    nmi_req = 1;
    for (int i = 0; i < 5; i++) begin
      tick();
      if (accept) n++;
    end
    chk("R12 one accept for held nmi", n, 1);
    nmi_req = 0; tick();
  endtask

  task automatic t_override();
    strobe_enable();
    int_req = 1; cmd_enable = 1; tick(); clear_in();
    chk("R14 accept", accept, 1);
    chk("R14 pri cleared over enable", en_pri, 0);
    chk("R14 bak cleared over enable", en_bak, 0);
    tick();
    strobe_enable();
    nmi_req = 1; cmd_disable = 1; tick(); clear_in();
    chk("R14 nmi pri", en_pri, 0);
    chk("R14 nmi bak kept over disable", en_bak, 1);
    tick();
  endtask

  initial begin
    clear_in();
    t_reset();
    t_modesel();
    t_masked();
    t_flags();
    t_vecload();
    t_nmi();
    t_both();
    t_held();
    t_override();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule